// File: doc/BRIEF.md
# Local Bus Cycle Length Controller

This block runs single read and write transfers on a simple local bus for a host-side bridge. The host raises a request with an address, a direction and write data. The block then drives the local address, data and strobes, and returns an acknowledge pulse with read data and an error flag. A small configuration register sets how each transfer ends. The transfer can wait for an external ready input, which a timeout guards. Or it can run for a fixed count of 1 to 11 local clock periods, and then the ready input has no effect.

When arbitration is turned on, every transfer first raises a bus request and waits for a grant. The block holds a grant-acknowledge output for the length of the strobes, and it drops the bus request one clock after the strobes end. When arbitration is off, the arbitration outputs stay low and a transfer starts at once. A separate configuration bit decides whether the local clock is driven onto its pin.

The hardware reset clears the configuration register. The soft reset aborts any transfer in progress and leaves the register unchanged. The configuration is sampled when a transfer is accepted.

Top module: `lbc_top`

## Requirements
- R1: Hardware reset `rst` clears the configuration register to zero: clock pin not driven, arbitration off, ready-wait mode. The soft reset `soft_rst` returns the sequencer to idle and drops every strobe, but leaves the configuration register unchanged.
- R2: The configuration word is {code[5:2], arb_en[1], clk_en[0]}. `lclk_oe` follows clk_en in the cycle after the write edge, and `lclk_o` carries the local clock.
- R3: With code 0, the strobes stay high until `lb_rdy` is sampled high at a clock edge while they are high. That edge ends the transfer and captures `lb_rdata` into `hrdata`.
- R4: With a code from 1 to 11, the strobes stay high for exactly that many clock cycles, whatever `lb_rdy` does.
- R5: A code from 12 to 15 makes the block acknowledge the request one cycle after acceptance with `herr` high. No strobe and no bus request is raised.
- R6: With arbitration on, `lb_req` rises the cycle after acceptance. The strobes start the cycle after `lb_gnt` is sampled high. `lb_gack` is high in exactly the cycles the strobes are high.
- R7: With arbitration off, `lb_req` and `lb_gack` stay low, and the strobes start the cycle after the request is accepted.
- R8: With arbitration on, `lb_req` is still high in the first cycle after the strobes fall and is low in the cycle after that.
- R9: The code and the arbitration bit are sampled when a request is accepted. A register write during a transfer affects only later transfers.
- R10: In ready-wait mode, a transfer whose strobes have been high for TMO_LIMIT cycles without ready ends with `herr` high. If ready arrives in that final cycle, the transfer ends without error.
- R11: `hack` is a one-cycle pulse in the first cycle the strobes are low. `lb_rd` and `lb_wr` are mutually exclusive and follow `hwrite`. `lb_addr` and `lb_wdata` hold the request's address and data while the strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the local bus clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Synchronous soft reset of the sequencer, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration word {code, arb_en, clk_en} |
| hreq | input | 1 | Host request, held until `hack` |
| hwrite | input | 1 | 1 = write, 0 = read |
| haddr | input | AW | Host address |
| hwdata | input | DW | Host write data |
| hack | output | 1 | Transfer done pulse |
| herr | output | 1 | Error flag, valid with `hack` |
| hrdata | output | DW | Read data, valid with `hack` |
| lb_req | output | 1 | Bus request |
| lb_gnt | input | 1 | Bus grant |
| lb_gack | output | 1 | Grant acknowledge |
| lb_cs | output | 1 | Transfer strobe |
| lb_rd | output | 1 | Read strobe |
| lb_wr | output | 1 | Write strobe |
| lb_addr | output | AW | Local address |
| lb_wdata | output | DW | Local write data |
| lb_rdata | input | DW | Local read data |
| lb_rdy | input | 1 | External ready |
| lclk_o | output | 1 | Local clock |
| lclk_oe | output | 1 | Local clock pin drive enable |

## Verification
A wrong cycle counter or a wrong end condition shows up as a strobe pulse of the wrong length, measured in the same transfer. A sequencer stuck in the request or release state shows up as a missing acknowledge or as `lb_req` high one cycle too long, both seen within a cycle of the expected end. Corrupted configuration or snapshot state shows up on the next transfer, as a wrong length, an unexpected error, or arbitration pins that move when they should stay low. Every transfer is compared against lengths and start cycles computed in the bench from the code it wrote.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef struct packed {
    logic [3:0] code;
    logic       arb_en;
    logic       clk_en;
  } lbc_cfg_t;

  localparam int CFG_W    = $bits(lbc_cfg_t);
  localparam int CODE_MAX = 11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_BUS,
    ST_REL
  } lbc_state_e;
endpackage

// File: rtl/lbc_cfg_reg.sv
module lbc_cfg_reg
  import lbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output lbc_cfg_t         cfg_o
);
  always_ff @(posedge clk) begin
    if (rst)     cfg_o <= '0;
    else if (we) cfg_o <= lbc_cfg_t'(wdata);
  end
endmodule

// File: rtl/lbc_len_cnt.sv
module lbc_len_cnt #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          inc,
  output logic [TW-1:0] cnt
);
  localparam logic [TW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= TW'(1);
    else if (inc && cnt != TOP) cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/lbc_top.sv
module lbc_top
  import lbc_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int TMO_W     = 16,
  parameter int TMO_LIMIT = 65535
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             hreq,
  input  logic             hwrite,
  input  logic [AW-1:0]    haddr,
  input  logic [DW-1:0]    hwdata,
  output logic             hack,
  output logic             herr,
  output logic [DW-1:0]    hrdata,
  output logic             lb_req,
  input  logic             lb_gnt,
  output logic             lb_gack,
  output logic             lb_cs,
  output logic             lb_rd,
  output logic             lb_wr,
  output logic [AW-1:0]    lb_addr,
  output logic [DW-1:0]    lb_wdata,
  input  logic [DW-1:0]    lb_rdata,
  input  logic             lb_rdy,
  output logic             lclk_o,
  output logic             lclk_oe
);
  localparam logic [TMO_W-1:0] TMO_END = TMO_W'(TMO_LIMIT);

  lbc_cfg_t    cfg;
  lbc_state_e  state_q;
  logic [3:0]  snap_code;
  logic        snap_arb;
  logic        wr_q;
  logic [TMO_W-1:0] cnt;
  logic        seq_rst, accept, code_bad, go_direct, grant_go;
  logic        counted, end_now, end_err;

  assign seq_rst = rst | soft_rst;

  lbc_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg_o (cfg)
  );

  assign accept    = (state_q == ST_IDLE) && hreq && !hack;
  assign code_bad  = cfg.code > 4'(CODE_MAX);
  assign go_direct = accept && !code_bad && !cfg.arb_en;
  assign grant_go  = (state_q == ST_REQ) && lb_gnt;

  lbc_len_cnt #(.TW(TMO_W)) u_cnt (
    .clk  (clk),
    .rst  (seq_rst),
    .load (go_direct || grant_go),
    .inc  (state_q == ST_BUS),
    .cnt  (cnt)
  );

  assign counted = snap_code != 4'd0;
  assign end_now = counted ? (cnt == TMO_W'(snap_code)) : (lb_rdy || cnt == TMO_END);
  assign end_err = !counted && !lb_rdy;

  always_ff @(posedge clk) begin
    if (seq_rst) begin
      state_q   <= ST_IDLE;
      snap_code <= '0;
      snap_arb  <= 1'b0;
      wr_q      <= 1'b0;
      hack      <= 1'b0;
      herr      <= 1'b0;
      hrdata    <= '0;
      lb_req    <= 1'b0;
      lb_gack   <= 1'b0;
      lb_cs     <= 1'b0;
      lb_rd     <= 1'b0;
      lb_wr     <= 1'b0;
      lb_addr   <= '0;
      lb_wdata  <= '0;
    end else begin
      hack <= 1'b0;
      herr <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            snap_code <= cfg.code;
            snap_arb  <= cfg.arb_en;
            wr_q      <= hwrite;
            lb_addr   <= haddr;
            lb_wdata  <= hwdata;
            if (code_bad) begin
              hack <= 1'b1;
              herr <= 1'b1;
            end else if (cfg.arb_en) begin
              lb_req  <= 1'b1;
              state_q <= ST_REQ;
            end else begin
              lb_cs   <= 1'b1;
              lb_rd   <= !hwrite;
              lb_wr   <= hwrite;
              state_q <= ST_BUS;
            end
          end
        end
        ST_REQ: begin
          if (lb_gnt) begin
            lb_gack <= 1'b1;
            lb_cs   <= 1'b1;
            lb_rd   <= !wr_q;
            lb_wr   <= wr_q;
            state_q <= ST_BUS;
          end
        end
        ST_BUS: begin
          if (end_now) begin
            lb_gack <= 1'b0;
            lb_cs   <= 1'b0;
            lb_rd   <= 1'b0;
            lb_wr   <= 1'b0;
            hack    <= 1'b1;
            herr    <= end_err;
            hrdata  <= lb_rdata;
            state_q <= snap_arb ? ST_REL : ST_IDLE;
          end
        end
        ST_REL: begin
          lb_req  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign lclk_o  = clk;
  assign lclk_oe = cfg.clk_en;
endmodule

// File: rtl/lbc_chk.sv
module lbc_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          soft_rst,
  input logic [5:0]    cfg_bits,
  input logic [3:0]    snap_code,
  input logic          snap_arb,
  input logic [TW-1:0] cnt,
  input logic          lb_cs,
  input logic          lb_rd,
  input logic          lb_wr,
  input logic          lb_req,
  input logic          lb_gnt,
  input logic          lb_gack,
  input logic          hack
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> cfg_bits == 6'd0);

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst || soft_rst)
    lb_cs |-> (lb_rd ^ lb_wr));

  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (rst || soft_rst)
    hack |=> !hack);

  assert_ack_no_strobe_R11: assert property (@(posedge clk) disable iff (rst || soft_rst)
    hack |-> !lb_cs);

  assert_counted_len_R4: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (lb_cs && snap_code != 4'd0) |-> cnt <= TW'(snap_code));

  assert_no_bad_strobe_R5: assert property (@(posedge clk) disable iff (rst || soft_rst)
    lb_cs |-> snap_code <= 4'd11);

  assert_gack_tracks_R6: assert property (@(posedge clk) disable iff (rst || soft_rst)
    lb_gack |-> lb_cs);

  assert_grant_first_R6: assert property (@(posedge clk) disable iff (rst || soft_rst)
    ($rose(lb_cs) && snap_arb) |-> ($past(lb_gnt) && $past(lb_req) && lb_gack));

  assert_arb_quiet_R7: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (lb_cs && !snap_arb) |-> (!lb_req && !lb_gack));

  assert_req_release_R8: assert property (@(posedge clk) disable iff (rst || soft_rst)
    ($fell(lb_cs) && snap_arb) |-> lb_req);

  assert_req_drop_R8: assert property (@(posedge clk) disable iff (rst || soft_rst)
    ($fell(lb_cs) && snap_arb) |=> !lb_req);
endmodule

bind lbc_top lbc_chk #(.TW(TMO_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .soft_rst  (soft_rst),
  .cfg_bits  (cfg),
  .snap_code (snap_code),
  .snap_arb  (snap_arb),
  .cnt       (cnt),
  .lb_cs     (lb_cs),
  .lb_rd     (lb_rd),
  .lb_wr     (lb_wr),
  .lb_req    (lb_req),
  .lb_gnt    (lb_gnt),
  .lb_gack   (lb_gack),
  .hack      (hack)
);

// File: tb/sim_lbc_top.sv
module sim_lbc_top;
  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst = 1'b1, soft_rst = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic hreq = 1'b0, hwrite = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [DW-1:0] hwdata = '0;
  logic hack, herr;
  logic [DW-1:0] hrdata;
  logic lb_req, lb_gack, lb_cs, lb_rd, lb_wr;
  logic lb_gnt = 1'b0, lb_rdy = 1'b0;
  logic [AW-1:0] lb_addr;
  logic [DW-1:0] lb_wdata, lb_rdata;
  logic lclk_o, lclk_oe;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  assign lb_rdata = {lb_addr ^ 16'h5A3C, ~lb_addr};

  lbc_top #(.AW(AW), .DW(DW), .TMO_W(16), .TMO_LIMIT(TMO)) u0 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .hreq(hreq), .hwrite(hwrite), .haddr(haddr), .hwdata(hwdata),
    .hack(hack), .herr(herr), .hrdata(hrdata),
    .lb_req(lb_req), .lb_gnt(lb_gnt), .lb_gack(lb_gack), .lb_cs(lb_cs),
    .lb_rd(lb_rd), .lb_wr(lb_wr), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
    .lb_rdata(lb_rdata), .lb_rdy(lb_rdy), .lclk_o(lclk_o), .lclk_oe(lclk_oe)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int code, input int rd);
    if (code >= 12) return 0;
    if (code != 0)  return code;
    return (rd + 1 < TMO) ? rd + 1 : TMO;
  endfunction

  function automatic bit exp_err(input int code, input int rd);
    return (code >= 12) || (code == 0 && rd + 1 > TMO);
  endfunction

  function automatic logic [DW-1:0] exp_rdata(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  task automatic write_cfg(input bit ce, input bit arb, input int code);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {4'(code), arb, ce};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One transfer; code and arb are what the bench expects the block to use.
  task automatic xfer(input int code, input bit arb, input bit wr, input int gd, input int rd,
                      input bit mid_en, input logic [5:0] mid_val, input string tag);
    int cyc = 0, cs_n = 0, reqc = 0, first_cs = -1, viol = 0;
    bit got = 0, err = 0, req_at_ack = 0;
    logic [DW-1:0] rdat = '0;
    logic [AW-1:0] a = AW'($urandom);
    logic [DW-1:0] d = $urandom;
    @(negedge clk);
    hreq = 1'b1; hwrite = wr; haddr = a; hwdata = d;
    while (!got && cyc < 400) begin
      @(negedge clk);
      cyc++;
      cfg_we = 1'b0;
      if (lb_cs) begin
        cs_n++;
        if (first_cs < 0) first_cs = cyc;
        if (lb_gack != arb) viol |= 1;
        if (lb_wr != wr || lb_rd != !wr) viol |= 2;
        if (lb_addr != a || (wr && lb_wdata != d)) viol |= 4;
      end else if (lb_gack) viol |= 1;
      if (lb_req) reqc++;
      if (!arb && (lb_req || lb_gack)) viol |= 8;
      lb_gnt = arb && lb_req && reqc > gd;
      if (code == 0) lb_rdy = lb_cs && cs_n == rd + 1;
      else           lb_rdy = 1'($urandom);
      if (mid_en && lb_cs && cs_n == 1) begin
        cfg_we = 1'b1; cfg_wdata = mid_val;
      end
      if (hack) begin
        got = 1; err = herr; rdat = hrdata; req_at_ack = lb_req;
        if (lb_cs) viol |= 16;
        hreq = 1'b0;
      end
    end
    cfg_we = 1'b0; lb_rdy = 1'b0;
    chk(got, "R11", {tag, " ack seen"}, got, 1);
    chk(cs_n == exp_len(code, rd), code == 0 ? "R3" : (code >= 12 ? "R5" : "R4"),
        {tag, " strobe length"}, cs_n, exp_len(code, rd));
    chk(err == exp_err(code, rd), code == 0 ? "R10" : "R5", {tag, " error flag"}, err, exp_err(code, rd));
    chk(viol == 0, arb ? "R6" : "R7", {tag, " strobe/arb integrity"}, viol, 0);
    if (code >= 12) begin
      chk(cyc == 1, "R5", {tag, " illegal ack cycle"}, cyc, 1);
      chk(reqc == 0, "R5", {tag, " no bus request"}, reqc, 0);
    end else begin
      chk(first_cs == (arb ? gd + 2 : 1), arb ? "R6" : "R7", {tag, " strobe start"}, first_cs, arb ? gd + 2 : 1);
      if (!wr && !err) chk(rdat == exp_rdata(a), "R3", {tag, " read data"}, int'(rdat), int'(exp_rdata(a)));
      if (arb) begin
        chk(req_at_ack == 1'b1, "R8", {tag, " req held at end"}, req_at_ack, 1);
        @(negedge clk);
        chk(lb_req == 1'b0, "R8", {tag, " req released"}, lb_req, 0);
      end
    end
    lb_gnt = 1'b0;
    @(negedge clk);
    chk(hack == 1'b0, "R11", {tag, " ack one cycle"}, hack, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(lclk_oe == 1'b0, "R1", "reset clock drive", lclk_oe, 0);
    chk(!lb_cs && !lb_req && !lb_gack && !hack, "R1", "reset outputs idle", lb_cs, 0);
    xfer(0, 0, 0, 0, 2, 0, '0, "R1 default ready mode");

    write_cfg(1, 0, 0);
    chk(lclk_oe == 1'b1, "R2", "clock enabled", lclk_oe, 1);
    chk(lclk_o == clk, "R2", "clock passthrough", lclk_o, clk);
    write_cfg(0, 0, 0);
    chk(lclk_oe == 1'b0, "R2", "clock disabled", lclk_oe, 0);

    write_cfg(0, 0, 1);  xfer(1, 0, 1, 0, 0, 0, '0, "R4 code1");
    write_cfg(0, 0, 11); xfer(11, 0, 0, 0, 0, 0, '0, "R4 code11");
    for (int c = 12; c < 16; c++) begin
      write_cfg(0, c[0], c);
      xfer(c, 0, 0, 0, 0, 0, '0, "R5 illegal");
    end
    write_cfg(0, 1, 5); xfer(5, 1, 1, 3, 0, 0, '0, "R6 arb code5");
    write_cfg(0, 1, 0); xfer(0, 1, 0, 0, 0, 0, '0, "R8 arb ready");
    write_cfg(0, 0, 0); xfer(0, 0, 0, 0, TMO - 1, 0, '0, "R10 ready at limit");
    xfer(0, 0, 1, 0, 500, 0, '0, "R10 timeout");

    write_cfg(0, 0, 3);
    xfer(3, 0, 0, 0, 0, 1, {4'd7, 1'b1, 1'b0}, "R9 mid write");
    xfer(7, 1, 1, 1, 0, 0, '0, "R9 next uses new");

    write_cfg(1, 1, 4);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk(lclk_oe == 1'b1, "R1", "soft reset keeps cfg", lclk_oe, 1);
    xfer(4, 1, 0, 2, 0, 0, '0, "R1 after soft reset");

    for (int i = 0; i < 40; i++) begin
      int code = $urandom_range(0, 15);
      bit arb  = 1'($urandom);
      write_cfg(1'($urandom), arb, code);
      xfer(code, arb, 1'($urandom), $urandom_range(0, 3), $urandom_range(0, 6), 0, '0, "R11 random");
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule